// File: doc/BRIEF.md
# Iterative Byte Multiply/Divide Unit

This unit runs the two long arithmetic operations of an accumulator-style 8-bit core: an unsigned multiply and an unsigned divide of two operand bytes, called A and B. The sequencer pulses `start_i` with both operands and an operation select. The unit then spends one clock per result bit and hands back two result bytes, which are written into the A and B registers, together with a carry flag and an overflow flag.

Multiply uses shift-and-add. The low product byte replaces A and the high byte replaces B. Divide uses restoring shift-and-subtract. The quotient replaces A and the remainder replaces B. A divide with a zero divisor is flagged through the overflow flag.

`busy_o` shows that a calculation is in flight. `done_o` marks the cycle in which fresh results first appear. The result bytes and flags then hold until the next completion.

Top module: `octet_muldiv`

## Requirements
- R1: With `op_div_i` = 0 (multiply), the unit forms the unsigned 16-bit product of `a_i` and `b_i`. `a_o` receives product bits 7:0 and `b_o` receives bits 15:8.
- R2: With `op_div_i` = 1 (divide) and `b_i` non-zero, `a_o` receives the unsigned quotient `a_i / b_i` and `b_o` receives the remainder `a_i % b_i`.
- R3: Every completed operation, multiply or divide, leaves `cy_o` at 0.
- R4: After a multiply, `ov_o` is 1 exactly when the high product byte is non-zero, and 0 otherwise.
- R5: After a divide, `ov_o` is 1 when `b_i` was zero and 0 otherwise. With a zero divisor, the values of `a_o` and `b_o` are not specified.
- R6: Take a `start_i` sampled at clock edge k while the unit is idle. `busy_o` is 1 after edges k through k+7. `busy_o` is 0 and `done_o` is 1 after edge k+8. `done_o` lasts exactly one cycle.
- R7: A `start_i` sampled while `busy_o` is 1 is ignored. It changes neither the running result nor the completion time, and it produces no extra `done_o` pulse.
- R8: Synchronous active-high reset clears `a_o`, `b_o`, `cy_o`, `ov_o`, `busy_o` and `done_o` to 0. Outside a `done_o` cycle, the result bytes and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation; taken only when idle |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| a_i | input | 8 | Operand A (multiplicand / dividend) |
| b_i | input | 8 | Operand B (multiplier / divisor) |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | 8 | New A: product low byte or quotient |
| b_o | output | 8 | New B: product high byte or remainder |
| cy_o | output | 1 | Carry flag result |
| ov_o | output | 1 | Overflow flag result |

## Verification
The assertions assume two things about the inputs. First, reset is applied before the first clock edge. Second, operands and the select matter only in the cycle a request is accepted; they are free to change at any other time. The stimulus drives every input on the falling edge, holds `start_i` for a single cycle, and deliberately raises a second request in the middle of an operation with different operands to confirm that the latched values survive. The remainder-bound assertion assumes a non-zero divisor, so it is gated on that. Random divides with a zero divisor are checked only for the overflow flag.

// File: rtl/md_pkg.sv
`timescale 1ns/1ps
package md_pkg;

    localparam int DATA_W = 8;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef struct packed {
        logic cy;
        logic ov;
    } md_flags_t;

    // Overflow flag rule shared by both operations
    function automatic logic ov_rule(input md_op_e op, input logic hi_nonzero, input logic dvs_zero);
        return (op == OP_MUL) ? hi_nonzero : dvs_zero;
    endfunction

endpackage

// File: rtl/md_ctrl.sv
`timescale 1ns/1ps
module md_ctrl #(
    parameter int W = md_pkg::DATA_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;

    assign accept_o = start_i & ~busy_q;
    assign step_o   = busy_q;
    assign last_o   = busy_q && (cnt_q == LAST);
    assign busy_o   = busy_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last_o) |=> busy_q); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (done_q && !busy_q)); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1))); // R7

endmodule

// File: rtl/md_core.sv
`timescale 1ns/1ps
module md_core #(
    parameter int W = md_pkg::DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic           step_i,
    input  md_pkg::md_op_e op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output md_pkg::md_op_e op_o,
    output logic [W-1:0]   res_a_o,
    output logic [W-1:0]   res_b_o,
    output logic           dvs_zero_o
);
    import md_pkg::*;

    logic [W:0]   hi_q, hi_n;
    logic [W-1:0] lo_q, lo_n;
    logic [W-1:0] dvs_q;
    md_op_e       op_q;

    logic [W:0] sum;
    logic [W:0] shifted;
    logic [W:0] dvs_ext;

    assign dvs_ext = {1'b0, dvs_q};

    // One result bit per call of this block
    always_comb begin
        sum     = lo_q[0] ? (hi_q + dvs_ext) : hi_q;
        shifted = {hi_q[W-1:0], lo_q[W-1]};
        if (op_q == OP_MUL) begin
            hi_n = {1'b0, sum[W:1]};
            lo_n = {sum[0], lo_q[W-1:1]};
        end else if (shifted >= dvs_ext) begin
            hi_n = shifted - dvs_ext;
            lo_n = {lo_q[W-2:0], 1'b1};
        end else begin
            hi_n = shifted;
            lo_n = {lo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            dvs_q <= '0;
            op_q  <= OP_MUL;
        end else if (load_i) begin
            hi_q  <= '0;
            lo_q  <= a_i;
            dvs_q <= b_i;
            op_q  <= op_i;
        end else if (step_i) begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign op_o       = op_q;
    assign res_a_o    = lo_n;
    assign res_b_o    = hi_n[W-1:0];
    assign dvs_zero_o = (dvs_q == '0);

    AST_OPND_STABLE: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> ($stable(dvs_q) && $stable(op_q))); // R7
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (step_i && op_q == OP_DIV && dvs_q != '0) |-> (hi_n < dvs_ext)); // R2

endmodule

// File: rtl/md_result.sv
`timescale 1ns/1ps
module md_result #(
    parameter int W = md_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  md_pkg::md_op_e    op_i,
    input  logic [W-1:0]      res_a_i,
    input  logic [W-1:0]      res_b_i,
    input  logic              dvs_zero_i,
    output logic [W-1:0]      a_o,
    output logic [W-1:0]      b_o,
    output md_pkg::md_flags_t flags_o
);
    import md_pkg::*;

    logic [W-1:0] a_q, b_q;
    md_flags_t    flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            flags_q <= '0;
        end else if (load_i) begin
            a_q        <= res_a_i;
            b_q        <= res_b_i;
            flags_q.cy <= 1'b0;
            flags_q.ov <= ov_rule(op_i, |res_b_i, dvs_zero_i);
        end
    end

    assign a_o     = a_q;
    assign b_o     = b_q;
    assign flags_o = flags_q;

    AST_CY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !flags_q.cy); // R3
    AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == OP_DIV && dvs_zero_i) |=> flags_q.ov); // R5
    AST_DIV_OV_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == OP_DIV && !dvs_zero_i) |=> !flags_q.ov); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(a_q) && $stable(b_q) && $stable(flags_q))); // R8

endmodule

// File: rtl/octet_muldiv.sv
`timescale 1ns/1ps
module octet_muldiv (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       op_div_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] a_o,
    output logic [7:0] b_o,
    output logic       cy_o,
    output logic       ov_o
);
    import md_pkg::*;

    localparam int W = DATA_W;

    logic              accept, step, last;
    md_op_e            op_run;
    logic [W-1:0]      res_a, res_b;
    logic              dvs_zero;
    md_flags_t         flags;

    md_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .last_o   (last),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    md_core #(.W(W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .step_i     (step),
        .op_i       (md_op_e'(op_div_i)),
        .a_i        (a_i),
        .b_i        (b_i),
        .op_o       (op_run),
        .res_a_o    (res_a),
        .res_b_o    (res_b),
        .dvs_zero_o (dvs_zero)
    );

    md_result #(.W(W)) u_result (
        .clk        (clk),
        .rst        (rst),
        .load_i     (last),
        .op_i       (op_run),
        .res_a_i    (res_a),
        .res_b_i    (res_b),
        .dvs_zero_i (dvs_zero),
        .a_o        (a_o),
        .b_o        (b_o),
        .flags_o    (flags)
    );

    assign cy_o = flags.cy;
    assign ov_o = flags.ov;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R6
    AST_DONE_CY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cy_o); // R3

endmodule

// File: tb/octet_muldiv_test.sv
`timescale 1ns/1ps
module octet_muldiv_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       op_div_i = 1'b0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       busy_o, done_o, cy_o, ov_o;
    logic [7:0] a_o, b_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    octet_muldiv uut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_div_i(op_div_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
    );

    // {op, a, b, expected A, expected B, expected OV}; op 0 = multiply, 1 = divide
    localparam int NV = 11;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {1'b0, 8'h04, 8'h02, 8'h08, 8'h00, 1'b0},
        {1'b0, 8'hFF, 8'hFF, 8'h01, 8'hFE, 1'b1},
        {1'b0, 8'h10, 8'h10, 8'h00, 8'h01, 1'b1},
        {1'b0, 8'h00, 8'h37, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'h0F, 8'h11, 8'hFF, 8'h00, 1'b0},
        {1'b1, 8'h05, 8'h02, 8'h02, 8'h01, 1'b0},
        {1'b1, 8'hFF, 8'h01, 8'hFF, 8'h00, 1'b0},
        {1'b1, 8'h07, 8'h09, 8'h00, 8'h07, 1'b0},
        {1'b1, 8'hC8, 8'h0A, 8'h14, 8'h00, 1'b0},
        {1'b1, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0},
        {1'b1, 8'h80, 8'h03, 8'h2A, 8'h02, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request and wait for completion; lat counts falling edges until done
    task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] b, input bit check_timing);
        int lat;
        @(negedge clk);
        start_i = 1'b1; op_div_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (check_timing) chk("R6", "busy after accept", {15'd0, busy_o}, 16'd1);
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (check_timing) begin
            chk("R6", "latency", 16'(lat), 16'd9);
            chk("R6", "busy at done", {15'd0, busy_o}, 16'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", "reset a_o", {8'd0, a_o}, 16'd0);
        chk("R8", "reset b_o", {8'd0, b_o}, 16'd0);
        chk("R8", "reset flags", {14'd0, cy_o, ov_o}, 16'd0);
        chk("R8", "reset busy/done", {14'd0, busy_o, done_o}, 16'd0);
        rst = 1'b0;

        // Vector table: R1, R2, R4, R5, R3
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run_op(v[33], v[32:25], v[24:17], 1'b1);
            chk(v[33] ? "R2" : "R1", "table A", {8'd0, a_o}, {8'd0, v[16:9]});
            chk(v[33] ? "R2" : "R1", "table B", {8'd0, b_o}, {8'd0, v[8:1]});
            chk(v[33] ? "R5" : "R4", "table OV", {15'd0, ov_o}, {15'd0, v[0]});
            chk("R3", "table CY", {15'd0, cy_o}, 16'd0);
        end

        // R5 divide by zero sets OV
        run_op(1'b1, 8'h42, 8'h00, 1'b1);
        chk("R5", "div zero OV", {15'd0, ov_o}, 16'd1);
        chk("R3", "div zero CY", {15'd0, cy_o}, 16'd0);
        run_op(1'b1, 8'h42, 8'h05, 1'b1);
        chk("R5", "OV cleared after div", {15'd0, ov_o}, 16'd0);

        // R7 request during busy is ignored
        begin
            int lat;
            int extra;
            @(negedge clk);
            start_i = 1'b1; op_div_i = 1'b0; a_i = 8'h04; b_i = 8'h02;
            @(negedge clk);
            start_i = 1'b0; lat = 1;
            @(negedge clk); lat++;
            start_i = 1'b1; op_div_i = 1'b1; a_i = 8'hFF; b_i = 8'h01;
            @(negedge clk); lat++;
            start_i = 1'b0;
            while (!done_o && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            chk("R7", "latency with extra request", 16'(lat), 16'd9);
            chk("R7", "A unaffected", {8'd0, a_o}, 16'h0008);
            chk("R7", "B unaffected", {8'd0, b_o}, 16'h0000);
            extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done_o || busy_o) extra++;
            end
            chk("R7", "no second operation", 16'(extra), 16'd0);
            // R8 results held while idle
            chk("R8", "A held", {8'd0, a_o}, 16'h0008);
            chk("R8", "B held", {8'd0, b_o}, 16'h0000);
        end

        // R6 done lasts one cycle
        run_op(1'b0, 8'h03, 8'h05, 1'b1);
        @(negedge clk);
        chk("R6", "done single cycle", {15'd0, done_o}, 16'd0);

        // Random against reference arithmetic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ra, rb;
            logic       rop;
            logic [15:0] p;
            ra = 8'($urandom);
            rb = (n % 37 == 0) ? 8'h00 : 8'($urandom);
            rop = 1'($urandom);
            run_op(rop, ra, rb, 1'b0);
            if (!rop) begin
                p = 16'(ra) * 16'(rb);
                chk("R1", "rand mul", {b_o, a_o}, p);
                chk("R4", "rand mul OV", {15'd0, ov_o}, {15'd0, |p[15:8]});
            end else if (rb != 0) begin
                chk("R2", "rand quotient", {8'd0, a_o}, {8'd0, ra / rb});
                chk("R2", "rand remainder", {8'd0, b_o}, {8'd0, ra % rb});
                chk("R5", "rand div OV", {15'd0, ov_o}, 16'd0);
            end else begin
                chk("R5", "rand div zero OV", {15'd0, ov_o}, 16'd1);
            end
            chk("R3", "rand CY", {15'd0, cy_o}, 16'd0);
        end

        // R8 reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8", "reset clears results", {a_o, b_o}, 16'd0);
        chk("R8", "reset clears flags", {14'd0, cy_o, ov_o}, 16'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule